// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control of a successive-approximation analog-to-digital converter. A convert-start pulse arms it, and the pulse's falling edge begins a conversion. From then on a step timer, derived from the system clock, acts as a gated conversion clock. The block applies a trial word to a feedback DAC port, one bit at a time and MSB first. At the end of each conversion-clock period it reads a one-bit comparator input. That input decides whether the trial bit stays set or is cleared.

A full conversion takes one setup period, during which the register is cleared, plus one decision period per bit. For 12 bits that is 13 conversion-clock pulses. A resolution select ends the sequence early, after 10 or 8 decisions. Bits that are never decided remain at logic 0 in true form. The result appears as complemented (negative-true) parallel data. A separate true-MSB output lets a bipolar user choose between complementary offset binary and complementary two's complement. The status flag stays high from the start edge until one system-clock cycle after the last decision. The data is therefore already final when status falls.

States of the sequencer:
- IDLE: waiting for the start input to go high.
- ARMED: start is high; the block waits for it to fall.
- LOAD: the setup period; the register is cleared.
- RUN: the decision periods.
- SETTLE: the one-cycle delay before status falls.

Transitions between the states:
- IDLE to ARMED when start is high.
- ARMED to LOAD when start is low again.
- LOAD to RUN at the end of its period.
- RUN to RUN after each decision that is not the last.
- RUN to SETTLE after the last decision.
- SETTLE to IDLE unconditionally.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, busy and conv_clk are 0, dac_word is all zeros, data_n is all ones and msb_true is 0.
- R2: A conversion begins only after conv_start has been high and then returns low. Busy stays 0 while conv_start is held high. Busy rises within 4 system cycles of the falling edge.
- R3: conv_clk is 0 whenever busy is 0. During a conversion it gives exactly NB+1 high pulses, where NB is the number of converted bits: 13 pulses for a 12-bit conversion.
- R4: The first trial word applied to dac_word after the cleared setup period is 0x800, the MSB alone. Bits are decided from MSB to LSB.
- R5: In 12-bit mode (res_sel = 0), data_n equals the bitwise complement of the largest code that is not above the comparator threshold. This is complementary straight binary.
- R6: Busy stays high for exactly (NB+1)*2*DIV+1 system cycles: 53 for 12 bits, 45 for 10 bits and 37 for 8 bits when DIV = 2.
- R7: In the last cycle of busy, data_n already holds the final result. The result does not change when busy falls.
- R8: res_sel = 1 converts the 10 upper bits and res_sel = 2 converts the 8 upper bits. The bits that are not converted read 1 in data_n. res_sel = 3 acts as 12-bit mode.
- R9: msb_true is the true-form MSB, equal to the complement of data_n[11], for use as the MSB of complementary two's complement.
- R10: A start pulse that arrives while busy is high is ignored. No second conversion follows, and data_n keeps its value afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Convert-start pulse; its falling edge starts a conversion |
| cmp_keep | input | 1 | Comparator result: 1 keeps the current trial bit |
| res_sel | input | 2 | Resolution: 0 = 12 bits, 1 = 10 bits, 2 = 8 bits, 3 = 12 bits |
| busy | output | 1 | Status flag, high during a conversion |
| conv_clk | output | 1 | Gated conversion clock, low when idle |
| dac_word | output | 12 | Trial word for the feedback DAC, true form |
| data_n | output | 12 | Negative-true parallel result |
| msb_true | output | 1 | True-form MSB, for two's-complement coding |

## Verification
A wrong sequencer state shows up as a busy period whose length differs from (NB+1)*2*DIV+1 cycles, or as a conversion-clock pulse count other than NB+1. Either appears at the very conversion in which the state goes wrong. A fault in the register's bit index or in a keep/drop decision changes the complemented result. It also moves the first trial word away from 0x800, and that happens within the first decision period. The bench drives an ideal comparator built from its own analog code. It then compares each result, duration and pulse count with values computed from the requirements, across all three resolutions and across codes at both ends of the range and at mid scale.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LOAD,
        ST_RUN,
        ST_SETTLE
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_FULL = 2'd0,
        RES_A    = 2'd1,
        RES_B    = 2'd2,
        RES_ALT  = 2'd3
    } res_mode_t;

endpackage

// File: rtl/sar_conv_sync.sv
module sar_conv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/sar_conv_timer.sv
module sar_conv_timer #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick,
    output logic phase_hi
);
    localparam int PER = 2 * DIV;
    localparam int CW  = $clog2(PER);

    logic [CW-1:0] ph_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt <= '0;
        end else if (!run || tick) begin
            ph_cnt <= '0;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    assign tick     = run && (ph_cnt == CW'(PER - 1));
    assign phase_hi = run && (ph_cnt < CW'(DIV));
endmodule

// File: rtl/sar_conv_reg.sv
module sar_conv_reg #(
    parameter int W = 12,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          seed,
    input  logic          decide,
    input  logic          keep,
    input  logic [IW-1:0] idx,
    input  logic [IW-1:0] last_idx,
    output logic [W-1:0]  word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (seed) begin
            word[W-1] <= 1'b1;
        end else if (decide) begin
            if (!keep) begin
                word[idx] <= 1'b0;
            end
            if (idx > last_idx) begin
                word[idx - 1'b1] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int W      = 12,
    parameter int DIV    = 2,
    parameter int DROP_A = 2,
    parameter int DROP_B = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_start,
    input  logic         cmp_keep,
    input  logic [1:0]   res_sel,
    output logic         busy,
    output logic         conv_clk,
    output logic [W-1:0] dac_word,
    output logic [W-1:0] data_n,
    output logic         msb_true
);
    localparam int IW = $clog2(W);

    seq_state_t    state, state_nx;
    logic          start_s;
    logic          tick;
    logic          phase_hi;
    logic          run;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic [1:0]    res_q;
    logic          clear, seed, decide;
    logic [W-1:0]  word;

    sar_conv_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (conv_start),
        .dout (start_s)
    );

    sar_conv_timer #(.DIV(DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .phase_hi(phase_hi)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_s) state_nx = ST_ARMED;
            ST_ARMED:  if (!start_s) state_nx = ST_LOAD;
            ST_LOAD:   if (tick) state_nx = ST_RUN;
            ST_RUN:    if (tick && idx == last_idx) state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // resolution and bit index, captured per conversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_FULL;
            idx   <= '0;
        end else begin
            if (state == ST_ARMED && !start_s) begin
                res_q <= res_sel;
            end
            if (state == ST_LOAD && tick) begin
                idx <= IW'(W - 1);
            end else if (state == ST_RUN && tick && idx != last_idx) begin
                idx <= idx - 1'b1;
            end
        end
    end

    always_comb begin
        case (res_mode_t'(res_q))
            RES_A:   last_idx = IW'(DROP_A);
            RES_B:   last_idx = IW'(DROP_B);
            default: last_idx = '0;
        endcase
    end

    // outputs and register controls
    always_comb begin
        run    = 1'b0;
        busy   = 1'b0;
        clear  = 1'b0;
        seed   = 1'b0;
        decide = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ARMED: begin
                clear = !start_s;
            end
            ST_LOAD: begin
                run  = 1'b1;
                busy = 1'b1;
                seed = tick;
            end
            ST_RUN: begin
                run    = 1'b1;
                busy   = 1'b1;
                decide = tick;
            end
            ST_SETTLE: begin
                busy = 1'b1;
            end
            default: begin
            end
        endcase
    end

    sar_conv_reg #(.W(W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .seed    (seed),
        .decide  (decide),
        .keep    (cmp_keep),
        .idx     (idx),
        .last_idx(last_idx),
        .word    (word)
    );

    assign conv_clk = phase_hi;
    assign dac_word = word;
    assign data_n   = ~word;
    assign msb_true = word[W-1];
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_start,
    input logic         busy,
    input logic         conv_clk,
    input logic [W-1:0] dac_word,
    input logic [W-1:0] data_n
);
    // R3
    clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !conv_clk);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !conv_start);

    // R4
    cleared_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_word == '0));

    // R7
    final_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $stable(data_n));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_start) |=> busy);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .busy      (busy),
    .conv_clk  (conv_clk),
    .dac_word  (dac_word),
    .data_n    (data_n)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
    localparam int W   = 12;
    localparam int DIV = 2;

    typedef struct {
        logic [W-1:0] exp_data_n;
        int           exp_cycles;
        int           exp_pulses;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_start = 1'b0;
    logic [1:0]   res_sel = 2'd0;
    logic [W-1:0] vin = '0;
    logic         cmp_keep;
    logic         busy, conv_clk, msb_true;
    logic [W-1:0] dac_word, data_n;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    assign cmp_keep = (vin >= dac_word);

    sar_conv_ctrl #(.W(W), .DIV(DIV)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_start(conv_start),
        .cmp_keep  (cmp_keep),
        .res_sel   (res_sel),
        .busy      (busy),
        .conv_clk  (conv_clk),
        .dac_word  (dac_word),
        .data_n    (data_n),
        .msb_true  (msb_true)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // driver: one conversion, expected item pushed to the scoreboard
    task automatic convert(input logic [W-1:0] code, input logic [1:0] sel, input bit inject);
        exp_t e;
        int   nb;
        logic [W-1:0] mask;
        bit   idle_ok;
        bit   seen;
        nb   = (sel == 2'd1) ? 10 : (sel == 2'd2) ? 8 : 12;
        mask = {W{1'b1}} << (W - nb);
        e.exp_data_n = ~(code & mask);
        e.exp_cycles = (nb + 1) * 2 * DIV + 1;
        e.exp_pulses = nb + 1;
        e.tag        = (sel == 2'd0) ? "R5" : "R8";
        q.push_back(e);
        @(negedge clk);
        vin        = code;
        res_sel    = sel;
        conv_start = 1'b1;
        idle_ok    = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (busy) idle_ok = 1'b0;
        end
        check(idle_ok, "R2 busy while start high", 32'(busy), 0);
        conv_start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        check(seen, "R2 busy after start fall", 32'(seen), 1);
        if (inject) begin
            repeat (8) @(negedge clk);
            conv_start = 1'b1;
            repeat (5) @(negedge clk);
            conv_start = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor
    bit           prev_busy = 1'b0;
    bit           prev_cc   = 1'b0;
    int           bcnt, pcnt;
    logic [W-1:0] first_tr, last_data;
    bit           got_tr;
    bit           idle_clk_bad = 1'b0;

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (busy && !prev_busy) begin
                    bcnt = 0; pcnt = 0; got_tr = 1'b0; first_tr = '0;
                end
                if (!busy && conv_clk) idle_clk_bad = 1'b1;
                if (busy) begin
                    bcnt++;
                    if (conv_clk && !prev_cc) pcnt++;
                    if (!got_tr && dac_word != '0) begin
                        got_tr = 1'b1; first_tr = dac_word;
                    end
                    last_data = data_n;
                end
                if (prev_busy && !busy) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R10 unexpected conversion", 1, 0);
                    end else begin
                        e = q.pop_front();
                        check(data_n == e.exp_data_n, e.tag, 32'(data_n), 32'(e.exp_data_n));
                        check(last_data == e.exp_data_n, "R7 data before busy falls",
                              32'(last_data), 32'(e.exp_data_n));
                        check(bcnt == e.exp_cycles, "R6 busy length", bcnt, e.exp_cycles);
                        check(pcnt == e.exp_pulses, "R3 clock pulses", pcnt, e.exp_pulses);
                        check(first_tr == 12'h800, "R4 first trial", 32'(first_tr), 32'h800);
                        check(msb_true == ~data_n[W-1], "R9 true msb",
                              32'(msb_true), 32'(~data_n[W-1]));
                    end
                end
                prev_busy = busy;
                prev_cc   = conv_clk;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : main
        logic [W-1:0] held;
        bit stay_idle;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0 && conv_clk == 1'b0, "R1 busy/clk", 32'({busy, conv_clk}), 0);
        check(dac_word == '0, "R1 dac", 32'(dac_word), 0);
        check(data_n == '1 && msb_true == 1'b0, "R1 data_n", 32'(data_n), 32'hFFF);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        convert(12'h676, 2'd0, 1'b0);
        convert(12'hFFF, 2'd0, 1'b0);
        convert(12'h000, 2'd0, 1'b0);
        convert(12'h800, 2'd0, 1'b0);
        convert(12'h7FF, 2'd0, 1'b0);
        convert(12'hABF, 2'd1, 1'b0);   // R8 10-bit
        convert(12'h5A7, 2'd2, 1'b0);   // R8 8-bit
        convert(12'h3C9, 2'd3, 1'b0);   // R8 code 3 acts as 12-bit

        // R10 start during busy ignored
        convert(12'h9D3, 2'd0, 1'b1);
        held = data_n;
        stay_idle = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (busy || data_n != held) stay_idle = 1'b0;
        end
        check(stay_idle, "R10 no second conversion", 32'(data_n), 32'(held));
        check(q.size() == 0, "R10 scoreboard drained", q.size(), 0);
        check(!idle_clk_bad, "R3 clock low when idle", 32'(idle_clk_bad), 0);
        finish_run();
    end
endmodule